// File: doc/BRIEF.md
# Parallel Program-Verify Port Controller

This block is the target side of a byte-parallel programming port for a 16-bit-word one-time-programmable memory. An external programmer holds a test pin and three mode-select pins at fixed levels, releases the reset/programming-voltage pin and presents an entry key on the high-byte port. After that it works the memory through two strobes: an address/verify strobe and a program strobe. Both ports are bidirectional and are modelled here as separate input, output and output-enable signals.

Every pin is sampled once per instruction-cycle tick, and all sequencing runs on those samples. The first address/verify rising edge after entry latches a 16-bit address. Later rising edges of that strobe alternate between driving the stored word onto the ports and stepping to the next word. A program strobe pulse clears bits of the current word. The order of the address/verify edge and the program strobe's falling edge selects the next step: verify the same word, step to the next word, or program the same word again. The memory is a register array of `DEPTH` words that reads as all ones after chip reset.

Top module: `pvp_ctrl`

## Requirements
- R1: Entry succeeds only when, at the tick that sees the reset/programming pin rise, the test pin is 1, `sel_i` equals 3'b100 and `hi_i` equals 8'hE1. With the test pin low or any other select value, later strobes never enable the ports.
- R2: If the entry conditions fail, the block halts. Until the reset/programming pin goes low again, strobes neither drive the ports nor change memory.
- R3: After entry, the first rising edge of the address/verify strobe latches the address {`hi_i`,`lo_i`}. The word used is the address modulo `DEPTH`, so address 0x0050 selects the same word as 0x0010 when `DEPTH` is 64.
- R4: In verify, rising edges of the address/verify strobe alternate. The first drives the current word (high byte on `hi_o`, low byte on `lo_o`) with both output enables at 1. The next releases the ports and increments the address.
- R5: Whenever the block is not driving verify data, both output enables are 0 and both output buses are 0. This holds after reset, after an address load and while programming.
- R6: A program strobe rising edge starts a program cycle. The data on the ports is captured at the third tick in that cycle, and later changes are ignored. A pulse that ends before the capture writes nothing.
- R7: Programming stores the bitwise AND of the captured data and the old word, so bits can only be cleared. After chip reset every word reads 0xFFFF.
- R8: If the address/verify strobe rises while the program strobe is still high, or at the tick that sees the program strobe fall, the block returns to verify at the same address.
- R9: If the address/verify strobe rises after the program strobe has fallen, the address increments and verify starts at the next word.
- R10: If the program strobe rises again while the address/verify strobe stays low, the same word is programmed again and accumulates the AND of both data values.
- R11: A low level on the reset/programming pin returns the block to idle with the ports released. A new address can be loaded only after entry is repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high chip reset |
| tick_i | input | 1 | One-cycle instruction-cycle pulse; pins are sampled on it |
| test_i | input | 1 | Test-mode pin |
| mclr_i | input | 1 | Reset/programming-voltage pin as a logic level |
| sel_i | input | 3 | Mode-select pins, 3'b100 required for entry |
| prg_stb_i | input | 1 | Program strobe |
| adv_stb_i | input | 1 | Address/verify strobe |
| hi_i | input | 8 | High-byte port, input side |
| lo_i | input | 8 | Low-byte port, input side |
| hi_o | output | 8 | High-byte port, output side |
| lo_o | output | 8 | Low-byte port, output side |
| hi_oe | output | 1 | High-byte port output enable |
| lo_oe | output | 1 | Low-byte port output enable |

## Verification
The hardest cases to reach are the timing relations inside a program cycle, and the bench only sees their results after later strobe edges. To tell the three exits apart, each exit writes a different pattern. A fresh entry then reads the words back in sequence, so a wrong increment or a missing one shifts every later value. The capture instant is tested by changing the port data partway through a long pulse. The short-pulse case uses a program pulse exactly one tick long, so only one sample sees it high.

// File: rtl/pvp_pkg.sv
package pvp_pkg;

    localparam int unsigned PORT_W = 8;
    localparam int unsigned WORD_W = 2 * PORT_W;

    localparam logic [PORT_W-1:0] ENTRY_KEY = 8'hE1;
    localparam logic [2:0]        SEL_PROG  = 3'b100;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HALT,
        ST_LOAD,
        ST_VER,
        ST_PROG,
        ST_DEC
    } pvp_state_e;

    typedef struct packed {
        logic mclr;
        logic prg;
        logic adv;
    } ctl_s;

    typedef struct packed {
        logic              test;
        logic [2:0]        sel;
        ctl_s              ctl;
        logic [PORT_W-1:0] hi;
        logic [PORT_W-1:0] lo;
    } pin_s;

    typedef struct packed {
        logic mclr_rise;
        logic mclr_low;
        logic prg_rise;
        logic prg_fall;
        logic adv_rise;
    } evt_s;

    function automatic logic entry_ok(pin_s p);
        return p.test && (p.sel == SEL_PROG) && (p.hi == ENTRY_KEY);
    endfunction

endpackage

// File: rtl/pvp_sync.sv
module pvp_sync
    import pvp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  pin_s              pins_i,
    output evt_s              evt_o,
    output logic              entry_ok_o,
    output logic [PORT_W-1:0] hi_o,
    output logic [PORT_W-1:0] lo_o
);

    pin_s cur_q;
    ctl_s prv_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
            prv_q <= '0;
        end else if (tick_i) begin
            cur_q <= pins_i;
            prv_q <= cur_q.ctl;
        end
    end

    always_comb begin
        evt_o.mclr_rise = cur_q.ctl.mclr & ~prv_q.mclr;
        evt_o.mclr_low  = ~cur_q.ctl.mclr;
        evt_o.prg_rise  = cur_q.ctl.prg & ~prv_q.prg;
        evt_o.prg_fall  = ~cur_q.ctl.prg & prv_q.prg;
        evt_o.adv_rise  = cur_q.ctl.adv & ~prv_q.adv;
    end

    assign entry_ok_o = entry_ok(cur_q);
    assign hi_o       = cur_q.hi;
    assign lo_o       = cur_q.lo;

endmodule

// File: rtl/pvp_array.sv
module pvp_array #(
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned WORD_W = 16,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] rdata_o
);

    logic [WORD_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '1;
            end
        end else if (we_i) begin
            mem_q[idx_i] <= mem_q[idx_i] & wdata_i;
        end
    end

    assign rdata_o = mem_q[idx_i];

endmodule

// File: rtl/pvp_fsm.sv
module pvp_fsm
    import pvp_pkg::*;
#(
    parameter int unsigned SAMPLE_TICKS = 3,
    localparam int unsigned ADDR_W = WORD_W,
    localparam int unsigned CNT_W  = $clog2(SAMPLE_TICKS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  evt_s              evt_i,
    input  logic              entry_ok_i,
    input  logic [PORT_W-1:0] hi_i,
    input  logic [PORT_W-1:0] lo_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              drv_o,
    output logic              we_o,
    output logic [WORD_W-1:0] wdata_o
);

    localparam logic [CNT_W-1:0]  CAP_AT = CNT_W'(SAMPLE_TICKS - 1);
    localparam logic [ADDR_W-1:0] ONE    = {{(ADDR_W-1){1'b0}}, 1'b1};

    pvp_state_e        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic              drv_q;
    logic              we_q;
    logic [WORD_W-1:0] dlat_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              have_q;
    logic              early_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            drv_q   <= 1'b0;
            we_q    <= 1'b0;
            dlat_q  <= '0;
            cnt_q   <= '0;
            have_q  <= 1'b0;
            early_q <= 1'b0;
        end else begin
            we_q <= 1'b0;
            if (tick_i) begin
                if (evt_i.mclr_low && state_q != ST_IDLE) begin
                    state_q <= ST_IDLE;
                    drv_q   <= 1'b0;
                end else begin
                    unique case (state_q)
                        ST_IDLE: begin
                            if (evt_i.mclr_rise) begin
                                state_q <= entry_ok_i ? ST_LOAD : ST_HALT;
                            end
                        end
                        ST_HALT: ;
                        ST_LOAD: begin
                            if (evt_i.adv_rise) begin
                                addr_q  <= {hi_i, lo_i};
                                drv_q   <= 1'b0;
                                state_q <= ST_VER;
                            end
                        end
                        ST_VER: begin
                            if (evt_i.prg_rise) begin
                                state_q <= ST_PROG;
                                drv_q   <= 1'b0;
                                cnt_q   <= '0;
                                have_q  <= 1'b0;
                                early_q <= 1'b0;
                            end else if (evt_i.adv_rise) begin
                                if (drv_q) begin
                                    drv_q  <= 1'b0;
                                    addr_q <= addr_q + ONE;
                                end else begin
                                    drv_q <= 1'b1;
                                end
                            end
                        end
                        ST_PROG: begin
                            if (evt_i.adv_rise) begin
                                early_q <= 1'b1;
                            end
                            if (evt_i.prg_fall) begin
                                we_q    <= have_q;
                                state_q <= (early_q || evt_i.adv_rise) ? ST_VER : ST_DEC;
                            end else if (cnt_q <= CAP_AT) begin
                                cnt_q <= cnt_q + 1'b1;
                                if (cnt_q == CAP_AT) begin
                                    dlat_q <= {hi_i, lo_i};
                                    have_q <= 1'b1;
                                end
                            end
                        end
                        ST_DEC: begin
                            if (evt_i.prg_rise) begin
                                state_q <= ST_PROG;
                                cnt_q   <= '0;
                                have_q  <= 1'b0;
                                early_q <= 1'b0;
                            end else if (evt_i.adv_rise) begin
                                addr_q  <= addr_q + ONE;
                                state_q <= ST_VER;
                            end
                        end
                        default: state_q <= ST_IDLE;
                    endcase
                end
            end
        end
    end

    assign addr_o  = addr_q;
    assign drv_o   = drv_q;
    assign we_o    = we_q;
    assign wdata_o = dlat_q;

    // R5
    drive_in_verify_chk: assert property (@(posedge clk) disable iff (rst)
        drv_q |-> state_q == ST_VER);

    // R6
    addr_hold_prog_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PROG) |=> $stable(addr_q));

    // R9
    addr_step_one_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(addr_q) && $past(state_q) != ST_LOAD) |-> addr_q == $past(addr_q) + ONE);

    // R6
    write_from_prog_chk: assert property (@(posedge clk) disable iff (rst)
        we_q |-> $past(state_q) == ST_PROG);

endmodule

// File: rtl/pvp_ctrl.sv
module pvp_ctrl
    import pvp_pkg::*;
#(
    parameter int unsigned DEPTH        = 64,
    parameter int unsigned SAMPLE_TICKS = 3,
    localparam int unsigned IDX_W  = $clog2(DEPTH),
    localparam int unsigned ADDR_W = WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              test_i,
    input  logic              mclr_i,
    input  logic [2:0]        sel_i,
    input  logic              prg_stb_i,
    input  logic              adv_stb_i,
    input  logic [7:0]        hi_i,
    input  logic [7:0]        lo_i,
    output logic [7:0]        hi_o,
    output logic [7:0]        lo_o,
    output logic              hi_oe,
    output logic              lo_oe
);

    pin_s              pins;
    evt_s              evt;
    logic              ent_ok;
    logic [PORT_W-1:0] s_hi;
    logic [PORT_W-1:0] s_lo;
    logic [ADDR_W-1:0] addr;
    logic              drv;
    logic              we;
    logic [WORD_W-1:0] wdata;
    logic [WORD_W-1:0] rd_word;
    logic              unused_addr_bits;

    always_comb begin
        pins.test     = test_i;
        pins.sel      = sel_i;
        pins.ctl.mclr = mclr_i;
        pins.ctl.prg  = prg_stb_i;
        pins.ctl.adv  = adv_stb_i;
        pins.hi       = hi_i;
        pins.lo       = lo_i;
    end

    pvp_sync u_sync (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick_i),
        .pins_i     (pins),
        .evt_o      (evt),
        .entry_ok_o (ent_ok),
        .hi_o       (s_hi),
        .lo_o       (s_lo)
    );

    pvp_fsm #(.SAMPLE_TICKS(SAMPLE_TICKS)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick_i),
        .evt_i      (evt),
        .entry_ok_i (ent_ok),
        .hi_i       (s_hi),
        .lo_i       (s_lo),
        .addr_o     (addr),
        .drv_o      (drv),
        .we_o       (we),
        .wdata_o    (wdata)
    );

    pvp_array #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_array (
        .clk     (clk),
        .rst     (rst),
        .we_i    (we),
        .idx_i   (addr[IDX_W-1:0]),
        .wdata_i (wdata),
        .rdata_o (rd_word)
    );

    assign unused_addr_bits = ^addr[ADDR_W-1:IDX_W];

    assign hi_oe = drv;
    assign lo_oe = drv;
    assign hi_o  = drv ? rd_word[WORD_W-1:PORT_W] : '0;
    assign lo_o  = drv ? rd_word[PORT_W-1:0]      : '0;

    // R7
    bits_only_clear_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> (rd_word & ~$past(rd_word)) == '0);

endmodule

// File: tb/tb_pvp_ctrl.sv
`timescale 1ns/1ps
module tb_pvp_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [1:0] tcnt = '0;
    logic       test_i = 1'b0;
    logic       mclr_i = 1'b0;
    logic [2:0] sel_i = '0;
    logic       prg = 1'b0;
    logic       adv = 1'b0;
    logic [7:0] hi_i = '0;
    logic [7:0] lo_i = '0;
    logic [7:0] hi_o;
    logic [7:0] lo_o;
    logic       hi_oe;
    logic       lo_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        tcnt <= tcnt + 2'd1;
        tick <= (tcnt == 2'd3);
    end

    pvp_ctrl dut (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick),
        .test_i    (test_i),
        .mclr_i    (mclr_i),
        .sel_i     (sel_i),
        .prg_stb_i (prg),
        .adv_stb_i (adv),
        .hi_i      (hi_i),
        .lo_i      (lo_i),
        .hi_o      (hi_o),
        .lo_o      (lo_o),
        .hi_oe     (hi_oe),
        .lo_oe     (lo_oe)
    );

    task automatic wt(input int n);
        repeat (n * 4) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [17:0] got, input logic [17:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic enter(input logic [7:0] key, input logic [2:0] sel, input logic tst);
        mclr_i = 1'b0; wt(12);
        test_i = tst; sel_i = sel; hi_i = key; wt(12);
        mclr_i = 1'b1; wt(12);
        hi_i = '0; wt(4);
    endtask

    task automatic load_addr(input logic [15:0] a);
        {hi_i, lo_i} = a;
        adv = 1'b1; wt(12);
        adv = 1'b0; wt(12);
    endtask

    task automatic adv_pulse();
        adv = 1'b1; wt(12);
        adv = 1'b0; wt(12);
    endtask

    // drives the current word; returns {hi_oe, lo_oe, hi_o, lo_o}
    task automatic read_word(output logic [17:0] v);
        adv = 1'b1; wt(12);
        v = {hi_oe, lo_oe, hi_o, lo_o};
        adv = 1'b0; wt(12);
    endtask

    task automatic prog_late(input logic [15:0] d);
        {hi_i, lo_i} = d;
        prg = 1'b1; wt(12);
        prg = 1'b0; wt(12);
        adv_pulse();
    endtask

    task automatic prog_early(input logic [15:0] d);
        {hi_i, lo_i} = d;
        prg = 1'b1; wt(12);
        adv = 1'b1; wt(12);
        prg = 1'b0; wt(12);
        adv = 1'b0; wt(12);
    endtask

    task automatic t_reset();
        chk("R5 reset outputs", {hi_oe, lo_oe, hi_o, lo_o}, 18'h0);
    endtask

    task automatic t_program_paths();
        logic [17:0] v;
        enter(8'hE1, 3'b100, 1'b1);
        load_addr(16'h0010);
        chk("R5 released after load", {hi_oe, lo_oe, hi_o, lo_o}, 18'h0);
        prog_late(16'h1234);              // 0x10, then step to 0x11
        prog_early(16'hABCD);             // 0x11, stay
        read_word(v);
        chk("R8 verify same word", v, {2'b11, 16'hABCD});
        adv_pulse();                      // release, step to 0x12
        chk("R4 release after second edge", {hi_oe, lo_oe, hi_o, lo_o}, 18'h0);
        {hi_i, lo_i} = 16'hF0F0;
        prg = 1'b1; wt(12); prg = 1'b0; wt(12);
        {hi_i, lo_i} = 16'h0FF0;
        prg = 1'b1; wt(12);
        chk("R5 released while programming", {hi_oe, lo_oe, hi_o, lo_o}, 18'h0);
        prg = 1'b0; wt(12);
        adv_pulse();                      // step to 0x13
        {hi_i, lo_i} = 16'h5A5A;
        prg = 1'b1; wt(8);
        {hi_i, lo_i} = 16'h0000; wt(8);
        prg = 1'b0; wt(12);
        adv_pulse();                      // step to 0x14
        {hi_i, lo_i} = 16'h0000;
        prg = 1'b1; wt(1);
        prg = 1'b0; wt(12);
        adv_pulse();                      // step to 0x15
        read_word(v);
        chk("R7 erased word", v, {2'b11, 16'hFFFF});
    endtask

    task automatic t_exit_idle();
        mclr_i = 1'b0; wt(12);
        chk("R11 idle releases ports", {hi_oe, lo_oe, hi_o, lo_o}, 18'h0);
        adv_pulse();
        adv = 1'b1; wt(12);
        chk("R11 no drive without entry", {hi_oe, lo_oe, hi_o, lo_o}, 18'h0);
        adv = 1'b0; wt(12);
    endtask

    task automatic t_readback();
        logic [17:0] v;
        enter(8'hE1, 3'b100, 1'b1);
        load_addr(16'h0010);
        read_word(v);
        chk("R3 load and verify", v, {2'b11, 16'h1234});
        adv_pulse();
        read_word(v);
        chk("R9 late edge stepped once", v, {2'b11, 16'hABCD});
        adv_pulse();
        read_word(v);
        chk("R10 reprogram accumulates", v, {2'b11, 16'h00F0});
        adv_pulse();
        read_word(v);
        chk("R6 capture at third tick", v, {2'b11, 16'h5A5A});
        adv_pulse();
        read_word(v);
        chk("R6 short pulse writes nothing", v, {2'b11, 16'hFFFF});
    endtask

    task automatic t_alias();
        logic [17:0] v;
        enter(8'hE1, 3'b100, 1'b1);
        load_addr(16'h0050);
        read_word(v);
        chk("R3 address modulo depth", v, {2'b11, 16'h1234});
    endtask

    task automatic t_bad_entry();
        logic [17:0] v;
        enter(8'h55, 3'b100, 1'b1);
        load_addr(16'h0010);
        read_word(v);
        chk("R2 halted no drive", v, 18'h0);
        prog_late(16'h0000);
        enter(8'hE1, 3'b000, 1'b1);
        load_addr(16'h0010);
        read_word(v);
        chk("R1 wrong select pins", v, 18'h0);
        enter(8'hE1, 3'b100, 1'b0);
        load_addr(16'h0010);
        read_word(v);
        chk("R1 test pin low", v, 18'h0);
        enter(8'hE1, 3'b100, 1'b1);
        load_addr(16'h0010);
        read_word(v);
        chk("R2 halted no write", v, {2'b11, 16'h1234});
    endtask

    initial begin
        repeat (10) @(negedge clk);
        rst = 1'b0;
        wt(4);
        t_reset();
        t_program_paths();
        t_exit_idle();
        t_readback();
        t_alias();
        t_bad_entry();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule